// File: doc/BRIEF.md
# Banked Data-Memory Address Generator

This block forms the physical register-file index for a small 8-bit core whose data memory holds 128 locations. Each access gives a 5-bit location field taken from the opcode. A location field of zero does not name real storage. It asks for an indirect access, and the address then comes from an 8-bit pointer register that this block holds. The two upper implemented pointer bits pick one of four banks. Direct accesses combine those bank bits with the opcode field. Indirect accesses use the seven low pointer bits as given.

Locations 0x00 to 0x0F of every bank fold onto bank 0, so the special-function registers and the shared general-purpose registers appear in all banks. Only locations 0x10 to 0x1F are private to each bank. The pointer register lives at folded location 0x04. A write that resolves there updates the pointer and does not go to storage. Pointer bit 7 does not exist and reads back as 1. When an indirect access resolves to location 0 itself, it is flagged as a null access. The core reads 0x00 for it, and a write does nothing.

Top module: `banked_addr_gen`

## Requirements
- R1: For a direct access (file_addr not 0), phys_addr[4:0] equals file_addr and phys_addr[6:5] equals pointer bits 6:5, unless R3 folds the bank.
- R2: For an indirect access (file_addr equal to 0), indirect is 1 and phys_addr is formed from pointer bits 6:0, unless R3 folds the bank.
- R3: Whenever phys_addr[4:0] is below 0x10, phys_addr[6:5] is 00. Low locations of banks 1 to 3 therefore alias to bank 0.
- R4: ptr_rd always shows 1 in bit 7 and the stored pointer bits in 6:0.
- R5: An access with acc_wr high that resolves to location 0x04 and is not null asserts ptr_sel. At the next clock edge the pointer loads wdata[6:0], and wdata[7] is ignored. The pointer keeps its value in every other cycle.
- R6: An indirect access whose pointer bits 4:0 are 0 raises null_acc, with phys_addr 0x00. It never asserts store_we or ptr_sel, and a write in that case leaves the pointer unchanged.
- R7: After a synchronous active-low reset, the pointer bits 6:0 are 0, so ptr_rd reads 0x80.
- R8: store_we equals acc_wr, except that it is 0 for null accesses and for accesses that hit the pointer location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| file_addr | input | 5 | Location field from the opcode; 0 selects indirect |
| acc_wr | input | 1 | The current access writes its destination |
| wdata | input | 8 | Write data, used when the pointer is the target |
| phys_addr | output | 7 | Folded physical index into the register file |
| indirect | output | 1 | The access goes through the pointer |
| null_acc | output | 1 | Indirect access that resolves to location 0 |
| ptr_sel | output | 1 | The access targets the pointer register |
| store_we | output | 1 | Write enable for register-file storage |
| ptr_rd | output | 8 | Pointer read-back, bit 7 forced to 1 |

## Verification
The bench builds the block with its default shape: two bank bits, a five-bit location field and a fold threshold of 0x10. With that shape the whole input space can be swept. All 128 pointer values are loaded in turn, and each one is paired with all 32 location fields, with writes both off and on. The bench computes the expected index, null, pointer-hit and write-enable values arithmetically for every pair. This covers every bank fold, every indirect path, including null and pointer-aliasing pointers, and the forced bit 7 of the read-back. Further directed cases cover reset, writes through the pointer and ignored writes.

// File: rtl/bank_addr_pkg.sv
// Package: shared types and helpers for the banked address generator.
// Assumes: the location field is never wider than 8 bits.
package bank_addr_pkg;

    typedef enum logic {
        MODE_DIRECT   = 1'b0,
        MODE_INDIRECT = 1'b1
    } acc_mode_e;

endpackage

// File: rtl/bfa_ptr_reg.sv
// Module: bfa_ptr_reg
// Holds the implemented low bits of the pointer register. Unimplemented
// high bits are not stored and read back as ones.
// Assumes: wr_en is already qualified (pointer location hit, not null).
module bfa_ptr_reg #(
    parameter int PTR_W  = 8,
    parameter int IMPL_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wdata,
    output logic [IMPL_W-1:0] ptr_q,
    output logic [PTR_W-1:0]  ptr_rd
);
    localparam int PAD_W = PTR_W - IMPL_W;

    // Purpose: store or clear the implemented pointer bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_en) begin
            ptr_q <= wdata[IMPL_W-1:0];
        end
    end

    // Purpose: build the read-back word with the missing bits set.
    always_comb begin
        ptr_rd = {{PAD_W{1'b1}}, ptr_q};
    end

    // R5: a load takes the low write-data bits on the following edge
    assert_ptr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ptr_q == $past(wdata[IMPL_W-1:0]));

    // R5/R6: no load request means the pointer holds its value
    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ptr_q));
endmodule

// File: rtl/bfa_addr_sel.sv
// Module: bfa_addr_sel
// Chooses between the direct address (bank bits + opcode field) and the
// indirect address (implemented pointer bits).
// Assumes: IND_LOC is the location value that requests indirection.
module bfa_addr_sel
    import bank_addr_pkg::*;
#(
    parameter int LOC_W   = 5,
    parameter int BANK_W  = 2,
    parameter int IND_LOC = 0
) (
    input  logic [LOC_W-1:0]        file_addr,
    input  logic [LOC_W+BANK_W-1:0] ptr_q,
    output acc_mode_e               mode,
    output logic [LOC_W+BANK_W-1:0] raw_addr
);
    localparam int PHYS_W = LOC_W + BANK_W;
    localparam logic [LOC_W-1:0] IND_CODE = LOC_W'(IND_LOC);

    // Purpose: decode indirection and merge bank bits with the location.
    always_comb begin
        if (file_addr == IND_CODE) begin
            mode     = MODE_INDIRECT;
            raw_addr = ptr_q;
        end else begin
            mode     = MODE_DIRECT;
            raw_addr = {ptr_q[PHYS_W-1:LOC_W], file_addr};
        end
    end
endmodule

// File: rtl/bfa_bank_fold.sv
// Module: bfa_bank_fold
// Folds the shared low window of every bank onto bank 0.
// Assumes: SHARED_N is at most 2**LOC_W.
module bfa_bank_fold #(
    parameter int LOC_W    = 5,
    parameter int BANK_W   = 2,
    parameter int SHARED_N = 16
) (
    input  logic [LOC_W+BANK_W-1:0] raw_addr,
    output logic [LOC_W+BANK_W-1:0] phys_addr
);
    localparam logic [LOC_W:0] LIMIT = (LOC_W+1)'(SHARED_N);

    // Purpose: clear the bank bits for locations in the shared window.
    always_comb begin
        if ({1'b0, raw_addr[LOC_W-1:0]} < LIMIT) begin
            phys_addr = {{BANK_W{1'b0}}, raw_addr[LOC_W-1:0]};
        end else begin
            phys_addr = raw_addr;
        end
    end
endmodule

// File: rtl/banked_addr_gen.sv
// Module: banked_addr_gen (top)
// Forms the folded physical register-file index for direct and indirect
// accesses, owns the pointer register, flags null indirect accesses and
// steers writes to either the pointer or the storage.
// Assumes: one access is presented per cycle; storage lives outside.
module banked_addr_gen
    import bank_addr_pkg::*;
#(
    parameter int LOC_W    = 5,
    parameter int BANK_W   = 2,
    parameter int PTR_W    = 8,
    parameter int SHARED_N = 16,
    parameter int IND_LOC  = 0,
    parameter int PTR_LOC  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LOC_W-1:0]              file_addr,
    input  logic                          acc_wr,
    input  logic [PTR_W-1:0]              wdata,
    output logic [LOC_W+BANK_W-1:0]       phys_addr,
    output logic                          indirect,
    output logic                          null_acc,
    output logic                          ptr_sel,
    output logic                          store_we,
    output logic [PTR_W-1:0]              ptr_rd
);
    localparam int PHYS_W = LOC_W + BANK_W;
    localparam logic [PHYS_W-1:0] PTR_IDX = PHYS_W'(PTR_LOC);
    localparam logic [PHYS_W-1:0] IND_IDX = PHYS_W'(IND_LOC);

    logic [PHYS_W-1:0] ptr_q;
    logic [PHYS_W-1:0] raw_addr;
    acc_mode_e         mode;
    logic              ptr_wr;

    bfa_ptr_reg #(.PTR_W(PTR_W), .IMPL_W(PHYS_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ptr_wr),
        .wdata  (wdata),
        .ptr_q  (ptr_q),
        .ptr_rd (ptr_rd)
    );

    bfa_addr_sel #(.LOC_W(LOC_W), .BANK_W(BANK_W), .IND_LOC(IND_LOC)) u_sel (
        .file_addr (file_addr),
        .ptr_q     (ptr_q),
        .mode      (mode),
        .raw_addr  (raw_addr)
    );

    bfa_bank_fold #(.LOC_W(LOC_W), .BANK_W(BANK_W), .SHARED_N(SHARED_N)) u_fold (
        .raw_addr  (raw_addr),
        .phys_addr (phys_addr)
    );

    // Purpose: classify the access and steer its write enable.
    always_comb begin
        indirect = (mode == MODE_INDIRECT);
        null_acc = indirect && (phys_addr == IND_IDX);
        ptr_sel  = !null_acc && (phys_addr == PTR_IDX);
        ptr_wr   = acc_wr && ptr_sel;
        store_we = acc_wr && !null_acc && !ptr_sel;
    end

    // R1: a direct access keeps the opcode location in the low bits
    assert_direct_loc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !indirect |-> phys_addr[LOC_W-1:0] == file_addr);

    // R3: a shared-window index never carries bank bits
    assert_fold_bank0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(phys_addr[LOC_W-1:0]) < SHARED_N) |-> phys_addr[PHYS_W-1:LOC_W] == '0);

    // R6: a null access neither writes storage nor hits the pointer
    assert_null_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        null_acc |-> (!store_we && !ptr_sel));

    // R6: a null write leaves the pointer read-back unchanged
    assert_null_keeps_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (null_acc && acc_wr) |=> $stable(ptr_rd));

    // R8: storage and pointer are never written together
    assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_we && ptr_sel));
endmodule

// File: tb/banked_addr_gen_tb.sv
module banked_addr_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] file_addr = '0;
    logic       acc_wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [6:0] phys_addr;
    logic       indirect, null_acc, ptr_sel, store_we;
    logic [7:0] ptr_rd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    banked_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .file_addr(file_addr), .acc_wr(acc_wr),
        .wdata(wdata), .phys_addr(phys_addr), .indirect(indirect),
        .null_acc(null_acc), .ptr_sel(ptr_sel), .store_we(store_we),
        .ptr_rd(ptr_rd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_phys(input int p, input int fa);
        int raw;
        raw = (fa == 0) ? (p & 8'h7F) : ((p & 8'h60) | fa);
        if ((raw & 5'h1F) < 16) raw = raw & 5'h1F;
        return raw;
    endfunction

    // one write cycle at a given location field
    task automatic wr_at(input int fa, input int d);
        @(negedge clk);
        file_addr = 5'(fa);
        wdata     = 8'(d);
        acc_wr    = 1'b1;
        @(negedge clk);
        acc_wr    = 1'b0;
        #1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        #1;
        chk("R7 reset read-back", ptr_rd, 8'h80);
        rst_n = 1'b1;

        // exhaustive sweep of pointer values and location fields
        for (int p = 0; p < 128; p++) begin
            wr_at(4, p | ((p & 1) << 7));   // R5: odd values also set wdata bit 7
            chk("R4/R5 read-back after load", ptr_rd, 8'h80 | p);
            for (int fa = 0; fa < 32; fa++) begin
                int ep;
                bit en, es;
                @(negedge clk);
                file_addr = 5'(fa);
                acc_wr    = 1'b0;
                #1;
                ep = exp_phys(p, fa);
                en = (fa == 0) && (ep == 0);
                es = !en && (ep == 4);
                chk(fa == 0 ? "R2/R3 indirect index" : "R1/R3 direct index", phys_addr, ep);
                chk("R2 indirect flag", indirect, fa == 0);
                chk("R6 null flag", null_acc, en);
                chk("R5 ptr_sel", ptr_sel, es);
                chk("R8 store_we idle", store_we, 0);
                acc_wr = 1'b1;
                #1;
                chk("R8 store_we on write", store_we, !en && !es);
                acc_wr = 1'b0;
            end
            chk("R5 pointer held across reads", ptr_rd, 8'h80 | p);
        end

        // null write: pointer in bank 1 location 0
        wr_at(4, 8'h20);
        wr_at(0, 8'h55);
        chk("R6 null write ignored", ptr_rd, 8'hA0);

        // indirect write reaching the pointer through a bank-3 alias
        wr_at(4, 8'h64);
        wr_at(0, 8'h3F);
        chk("R5 indirect write to pointer", ptr_rd, 8'hBF);

        // write to storage elsewhere does not touch the pointer
        wr_at(5'h1A, 8'h11);
        chk("R8 storage write keeps pointer", ptr_rd, 8'hBF);

        // reset again clears the pointer
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R7 reset clears pointer", ptr_rd, 8'h80);
        rst_n = 1'b1;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule